// File: doc/BRIEF.md
# Capture Trigger Unit

This block decides the moment a logic capture starts. A set of already-synchronised input channels is watched, but only the channels picked by an enable mask take part. Each picked channel has its own wanted level, high or low. A channel produces a trigger event only when it moves into its wanted level. The unit counts these events up to a programmed number. It then waits a programmed number of milliseconds and gives a single-cycle pulse to the capture controller.

A capture session starts with a one-cycle arm request. The mask, the level vector, the event count and the delay are sampled at that moment and held until the session ends. In the first cycle after arming, the unit checks the channels at once, so a channel that already sits at its wanted level counts as an event straight away. A status output stays high for the whole session. After the pulse, the unit is idle until the next arm. The millisecond time base comes from the system clock divided by a parameter, which by default gives 1 ms at 50 MHz.

Top module: `capture_trigger`

## Requirements
- R1: Channel i takes part only when chMask[i] is 1. It is at its wanted level when chIn[i] equals chPol[i], where 1 means high and 0 means low. Channels with a mask bit of 0 have no effect.
- R2: An event is an enabled channel entering its wanted level, compared with the previous cycle. Staying at that level gives no further event. Several channels entering in the same cycle count as one event.
- R3: In the first cycle after an arm is accepted, any enabled channel already at its wanted level counts as one event.
- R4: The unit fires on event number N, where N equals trigCount, and a trigCount of 0 is treated as 1. With a delay of 0, trigFired is high in the cycle after the clock edge that samples the final event.
- R5: With a delay of D (0 to 254), the pulse comes D*TICK_DIV cycles later than it would with D = 0.
- R6: With a mask of zero, the unit needs no event. It fires 1 + D*TICK_DIV clock edges after the edge that accepts arm.
- R7: trigFired lasts exactly one cycle. After it, waiting is low and further channel activity has no effect until the next arm.
- R8: waiting goes high at the edge that accepts arm and stays high until the firing edge. waiting and trigFired are never high together.
- R9: An arm request while waiting is ignored. Changes to chMask, chPol, trigCount or trigDelayMs while waiting have no effect on the current session.
- R10: During and after reset, trigFired and waiting are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chIn | input | NUM_CH | Synchronised channel levels |
| chMask | input | NUM_CH | Channel enable mask |
| chPol | input | NUM_CH | Wanted level for each channel (1 = high) |
| trigCount | input | CNT_W | Number of events needed (0 means 1) |
| trigDelayMs | input | DLY_W | Delay after the final event, in ms ticks |
| arm | input | 1 | One-cycle request to start a session |
| trigFired | output | 1 | One-cycle pulse that starts capture |
| waiting | output | 1 | High while a session is in progress |

## Verification
Two things can land in the same cycle. Several enabled channels can enter their wanted levels at once, and the initial-level check can meet the arming edge. The bench causes the first case by switching two enabled channels together and expects that to count as one event, so the pulse shows up only after a second joint switch. The bench causes the second case by arming while a channel already sits at its level and expects the pulse one edge after arming. An arm request that arrives in the middle of a session is also tested, and the pulse must keep its original timing.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DELAY = 2'd2
  } trig_state_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;        // latch configuration, clear event counter
    logic first;       // first sampling cycle of a session
    logic countEvt;    // a non-final event was seen
    logic startDelay;  // clear millisecond time base
    logic runDelay;    // advance millisecond time base
  } trig_strobe_t;

  // status from the datapath back to the control
  typedef struct packed {
    logic evt;         // qualifying event this cycle
    logic lastEvt;     // this event completes the count
    logic zeroDelay;   // latched delay is zero
    logic delayDone;   // final tick of the programmed delay
  } trig_status_t;

endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 8,
  parameter int DLY_W    = 8,
  parameter int TICK_DIV = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chIn,
  input  logic [NUM_CH-1:0] chMask,
  input  logic [NUM_CH-1:0] chPol,
  input  logic [CNT_W-1:0]  trigCount,
  input  logic [DLY_W-1:0]  trigDelayMs,
  input  trig_strobe_t      strb,
  output trig_status_t      stat
);

  localparam int TICK_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

  logic [NUM_CH-1:0] maskReg, polReg, prevAct, actNow;
  logic [CNT_W-1:0]  cntReg, evtCnt;
  logic [DLY_W-1:0]  dlyReg, msCnt;
  logic [TICK_W-1:0] tickCnt;
  logic              noSrc, tickWrap;
  logic [CNT_W:0]    evtNext, target;

  // per-channel level qualifier
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign actNow[i] = maskReg[i] & ~(chIn[i] ^ polReg[i]);
  end

  assign noSrc    = (maskReg == '0);
  assign evtNext  = {1'b0, evtCnt} + (CNT_W+1)'(1);
  assign target   = (cntReg == '0) ? (CNT_W+1)'(1) : {1'b0, cntReg};
  assign tickWrap = (tickCnt == TICK_LAST);

  always_comb begin
    if (strb.first) stat.evt = noSrc | (|actNow);
    else            stat.evt = |(actNow & ~prevAct);
    stat.lastEvt   = noSrc | (evtNext >= target);
    stat.zeroDelay = (dlyReg == '0);
    stat.delayDone = tickWrap && (msCnt == dlyReg - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      polReg  <= '0;
      cntReg  <= '0;
      dlyReg  <= '0;
      prevAct <= '0;
      evtCnt  <= '0;
      tickCnt <= '0;
      msCnt   <= '0;
    end else begin
      prevAct <= actNow;
      if (strb.load) begin
        maskReg <= chMask;
        polReg  <= chPol;
        cntReg  <= trigCount;
        dlyReg  <= trigDelayMs;
        evtCnt  <= '0;
      end
      if (strb.countEvt) evtCnt <= evtNext[CNT_W-1:0];
      if (strb.startDelay) begin
        tickCnt <= '0;
        msCnt   <= '0;
      end else if (strb.runDelay) begin
        if (tickWrap) begin
          tickCnt <= '0;
          msCnt   <= msCnt + 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  // R9: configuration is held for the whole session
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(cntReg) && $stable(dlyReg) && $stable(maskReg) && $stable(polReg)));

  // R5: the millisecond counter never passes the programmed delay while running
  a_r5_ms_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.runDelay |-> (msCnt < dlyReg));

  // R4: a non-final event never leaves the counter at or above its target
  a_r4_count_below: assert property (@(posedge clk) disable iff (!rstN)
    strb.countEvt |=> ({1'b0, evtCnt} < target));

endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         arm,
  input  trig_status_t stat,
  output trig_strobe_t strb,
  output logic         trigFired,
  output logic         waiting
);

  trig_state_e state, nxt;
  logic        firstFlag, fireNow;

  always_comb begin
    strb    = '0;
    nxt     = state;
    fireNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (arm) begin
          strb.load = 1'b1;
          nxt       = ST_COUNT;
        end
      end
      ST_COUNT: begin
        strb.first = firstFlag;
        if (stat.evt) begin
          if (stat.lastEvt) begin
            if (stat.zeroDelay) begin
              fireNow = 1'b1;
              nxt     = ST_IDLE;
            end else begin
              strb.startDelay = 1'b1;
              nxt             = ST_DELAY;
            end
          end else begin
            strb.countEvt = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        strb.runDelay = 1'b1;
        if (stat.delayDone) begin
          fireNow = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstFlag <= 1'b0;
      trigFired <= 1'b0;
    end else begin
      state     <= nxt;
      firstFlag <= strb.load;
      trigFired <= fireNow;
    end
  end

  assign waiting = (state != ST_IDLE);

  // R7: the fire pulse is one cycle wide
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    trigFired |=> !trigFired);

  // R8: pulse and waiting status are exclusive
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rstN)
    trigFired |-> !waiting);

  // R8: a session only begins after an arm request
  a_r8_rise_after_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> $past(arm));

  // R3: the first sampling cycle follows directly on acceptance of arm
  a_r3_first_after_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> strb.first);

endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
  import trig_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int CNT_W    = 8,
  parameter int DLY_W    = 8,
  parameter int TICK_DIV = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chIn,
  input  logic [NUM_CH-1:0] chMask,
  input  logic [NUM_CH-1:0] chPol,
  input  logic [CNT_W-1:0]  trigCount,
  input  logic [DLY_W-1:0]  trigDelayMs,
  input  logic              arm,
  output logic              trigFired,
  output logic              waiting
);

  trig_strobe_t strb;
  trig_status_t stat;

  trig_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .arm       (arm),
    .stat      (stat),
    .strb      (strb),
    .trigFired (trigFired),
    .waiting   (waiting)
  );

  trig_datapath #(
    .NUM_CH   (NUM_CH),
    .CNT_W    (CNT_W),
    .DLY_W    (DLY_W),
    .TICK_DIV (TICK_DIV)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .chIn        (chIn),
    .chMask      (chMask),
    .chPol       (chPol),
    .trigCount   (trigCount),
    .trigDelayMs (trigDelayMs),
    .strb        (strb),
    .stat        (stat)
  );

endmodule

// File: tb/test_capture_trigger.sv
module test_capture_trigger;

  localparam int TICK = 4;

  typedef struct packed {
    logic [7:0] mask;
    logic [7:0] pol;
    logic [7:0] cnt;
    logic [7:0] dly;
    logic [7:0] startV;
    logic [7:0] pulseV;
    int         expLat;   // edges after arm edge until pulse, 0 = never
  } vec_t;

  // channel levels alternate startV (odd cycles) / pulseV (even cycles)
  localparam vec_t VECS [12] = '{
    '{8'h01, 8'h01, 8'd0,   8'd0,   8'h01, 8'h00, 1},    // R3 already high at arm
    '{8'h01, 8'h01, 8'd0,   8'd0,   8'h00, 8'h01, 2},    // R2 rising into level
    '{8'h01, 8'h01, 8'd3,   8'd0,   8'h00, 8'h01, 6},    // R4 three events
    '{8'h04, 8'h00, 8'd2,   8'd0,   8'hFF, 8'hFB, 4},    // R1 low level on ch2
    '{8'h01, 8'h01, 8'd1,   8'd3,   8'h01, 8'h00, 13},   // R5 delay 3
    '{8'h00, 8'h00, 8'd5,   8'd2,   8'h00, 8'hFF, 9},    // R6 no sources
    '{8'h03, 8'h03, 8'd2,   8'd0,   8'h01, 8'h02, 2},    // R2 two channels in turn
    '{8'h02, 8'h02, 8'd0,   8'd0,   8'h00, 8'h01, 0},    // R1 masked channel ignored
    '{8'h01, 8'h01, 8'd254, 8'd0,   8'h00, 8'h01, 508},  // R4 maximum count
    '{8'h01, 8'h00, 8'd0,   8'd254, 8'h00, 8'h01, 1017}, // R5 maximum delay
    '{8'h01, 8'h01, 8'd2,   8'd0,   8'h01, 8'h01, 0},    // R2 held level ignored
    '{8'h03, 8'h03, 8'd2,   8'd0,   8'h00, 8'h03, 4}     // R2 joint entry = one event
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] chIn = '0, chMask = '0, chPol = '0, trigCount = '0, trigDelayMs = '0;
  logic       arm = 1'b0;
  logic       trigFired, waiting;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  capture_trigger #(.TICK_DIV(TICK)) i_capture_trigger (
    .clk(clk), .rstN(rstN), .chIn(chIn), .chMask(chMask), .chPol(chPol),
    .trigCount(trigCount), .trigDelayMs(trigDelayMs), .arm(arm),
    .trigFired(trigFired), .waiting(waiting)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int armAt, input bit scramble, output int got);
    int limit;
    rstN = 1'b0; arm = 1'b0;
    chMask = v.mask; chPol = v.pol; trigCount = v.cnt; trigDelayMs = v.dly;
    chIn = v.startV;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    arm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0;
    chk(waiting == 1'b1, "R8 waiting after arm", int'(waiting), 1);
    if (scramble) begin
      trigDelayMs = 8'd0; trigCount = 8'd5; chMask = 8'h00; chPol = ~v.pol;
    end
    limit = (v.expLat != 0) ? v.expLat + 20 : 60;
    got = 0;
    for (int k = 1; k <= limit; k++) begin
      chIn = (k % 2 == 1) ? v.startV : v.pulseV;
      arm  = (k == armAt);
      @(posedge clk);
      @(negedge clk);
      arm = 1'b0;
      if (trigFired) begin
        got = k;
        break;
      end
    end
  endtask

  initial begin
    int got;
    vec_t v;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(trigFired == 1'b0 && waiting == 1'b0, "R10 reset outputs", int'({trigFired, waiting}), 0);

    foreach (VECS[i]) begin
      runVec(VECS[i], 0, 1'b0, got);
      chk(got == VECS[i].expLat, $sformatf("R4 vector %0d latency", i), got, VECS[i].expLat);
      if (VECS[i].expLat != 0) begin
        @(negedge clk);
        chk(trigFired == 1'b0 && waiting == 1'b0, $sformatf("R7 vector %0d pulse end", i),
            int'({trigFired, waiting}), 0);
      end else begin
        chk(waiting == 1'b1, $sformatf("R1 vector %0d still waiting", i), int'(waiting), 1);
      end
    end

    // R7: after firing, channel activity does not fire again
    runVec(VECS[1], 0, 1'b0, got);
    for (int k = 0; k < 8; k++) begin
      chIn = (k % 2 == 0) ? 8'h00 : 8'h01;
      @(posedge clk);
      @(negedge clk);
      chk(trigFired == 1'b0 && waiting == 1'b0, "R7 idle after pulse", int'({trigFired, waiting}), 0);
    end

    // R9: arm during a session is ignored (re-arm at cycle 3 would restart count)
    v = '{8'h01, 8'h01, 8'd2, 8'd0, 8'h00, 8'h01, 4};
    runVec(v, 3, 1'b0, got);
    chk(got == 4, "R9 arm ignored while waiting", got, 4);

    // R9: configuration changes during a session are ignored
    v = '{8'h01, 8'h01, 8'd0, 8'd3, 8'h01, 8'h00, 13};
    runVec(v, 0, 1'b1, got);
    chk(got == 13, "R9 config held for session", got, 13);

    // R6: no sources with zero delay fires one edge after arm
    v = '{8'h00, 8'h00, 8'd9, 8'd0, 8'h00, 8'h00, 1};
    runVec(v, 0, 1'b0, got);
    chk(got == 1, "R6 empty mask zero delay", got, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule